// File: doc/BRIEF.md
# Neighbour-Comparison Fault Localizer for Replicated Modules

This block observes the scan-out bits of N identical module copies that are shifted with the same test pattern at the same time. Fault-free copies therefore present identical bits on every shift cycle. The block needs no stored expected response. It compares every copy with the copies on either side of it in a closed ring, so copy N-1 and copy 0 are neighbours. A copy whose bit disagrees with both neighbours is flagged in an N-bit fault word.

On every qualified shift cycle, the fault word is compressed into a 16-bit signature register. A shift-position counter advances on the same cycles. Any non-zero fault word is also written into a small on-chip event log, together with the counter value of that shift. Software clears the block with a synchronous clear at the start of a test session. At the end of the session it reads the signature, the event count, the overflow flag and each logged record through an index port.

Top module: `nbr_loc_top`

## Requirements
- R1: Fault bit i equals (b[i] XOR b[i-1]) AND (b[i] XOR b[i+1]), where b is the scan-out vector and the indices wrap modulo N. When all copies agree, the fault word is zero. The fault word is combinational from the inputs.
- R2: When exactly one copy deviates from all the others, exactly one fault bit is set, at that copy's index. This holds for every index, including 0 and N-1.
- R3: Multiple faults are reported without correction. Two deviating copies separated by one good copy (for example 1 and 3) set three consecutive bits (1, 2 and 3). Two adjacent deviating copies agree with each other, so they give a zero word.
- R4: The shift-position counter starts at 0 after clear. It increments by one on every clock with scan-enable high and holds otherwise.
- R5: On a clock with scan-enable high and a non-zero fault word, a record is written at index `evt_cnt` and `evt_cnt` increments. The record holds the counter value before the increment and the fault word.
- R6: With scan-enable low, nothing is logged and the counter, signature and event count hold, whatever the scan-out bits are.
- R7: Once `evt_cnt` equals the log depth, further events set `ovf`. `ovf` stays set until clear. `evt_cnt` stays at the depth, and the stored records do not change.
- R8: On each clock with scan-enable high, the signature becomes {sig[14:0],0} XOR (sig[15] ? 16'h002D : 0) XOR F. F is the fault word with bit i XORed into signature bit i mod 16. This is the polynomial x^16+x^5+x^3+x^2+1.
- R9: A synchronous clear (or reset) zeroes the counter, signature, `evt_cnt` and `ovf` on the next edge. Clear takes priority over scan-enable.
- R10: `rd_stamp` and `rd_word` show, combinationally, the record stored at `rd_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous session clear |
| scan_en | input | 1 | Qualifies counting, compaction and logging |
| scan_out | input | N_INST | One scan-out bit per module copy |
| rd_idx | input | $clog2(MEM_DEPTH) | Log read index |
| fault_word | output | N_INST | Current neighbour-vote fault word |
| sig | output | 16 | Signature register |
| evt_cnt | output | $clog2(MEM_DEPTH+1) | Number of stored records |
| ovf | output | 1 | Sticky log overflow |
| rd_stamp | output | CNT_W | Shift position of the selected record |
| rd_word | output | N_INST | Fault word of the selected record |

## Verification
The checker tests on every cycle that:
- an all-equal vector gives a zero word, and a single deviating bit gives exactly one fault bit;
- the event count steps by one per logged event and never passes the depth;
- overflow is sticky;
- the block holds its state while scan-enable is low, and clear returns it to zero.

Only the bench scenarios can show that:
- the fault bit lands at the right ring position, including across the wrap;
- multi-fault patterns come out as specified;
- each logged record carries the correct shift stamp;
- the signature follows the polynomial exactly;
- records stay intact after overflow.

// File: rtl/nbr_loc_pkg.sv
package nbr_loc_pkg;
    localparam int              SIG_W    = 16;
    localparam logic [SIG_W-1:0] SIG_POLY = 16'h002D;

    function automatic logic [SIG_W-1:0] sig_step(input logic [SIG_W-1:0] cur,
                                                  input logic [SIG_W-1:0] din);
        logic [SIG_W-1:0] fb;
        fb = cur[SIG_W-1] ? SIG_POLY : '0;
        return {cur[SIG_W-2:0], 1'b0} ^ fb ^ din;
    endfunction
endpackage

// File: rtl/nbr_loc_ring.sv
module nbr_loc_ring #(
    parameter int N = 8
) (
    input  logic [N-1:0] bits,
    output logic [N-1:0] word
);
    for (genvar i = 0; i < N; i++) begin : g_vote
        localparam int LEFT  = (i + N - 1) % N;
        localparam int RIGHT = (i + 1) % N;
        assign word[i] = (bits[i] ^ bits[LEFT]) & (bits[i] ^ bits[RIGHT]);
    end
endmodule

// File: rtl/nbr_loc_misr.sv
module nbr_loc_misr
    import nbr_loc_pkg::*;
#(
    parameter int N = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic [N-1:0]     word,
    output logic [SIG_W-1:0] sig
);
    logic [SIG_W-1:0] folded;

    always_comb begin
        folded = '0;
        for (int i = 0; i < N; i++) begin
            folded[i % SIG_W] = folded[i % SIG_W] ^ word[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sig <= '0;
        end else if (en) begin
            sig <= sig_step(sig, folded);
        end
    end
endmodule

// File: rtl/nbr_loc_log.sv
module nbr_loc_log #(
    parameter int N     = 8,
    parameter int CNT_W = 16,
    parameter int DEPTH = 16,
    localparam int IW   = $clog2(DEPTH),
    localparam int EW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic [N-1:0]     word,
    input  logic [IW-1:0]    rd_idx,
    output logic [EW-1:0]    evt_cnt,
    output logic             ovf,
    output logic [CNT_W-1:0] rd_stamp,
    output logic [N-1:0]     rd_word
);
    typedef struct packed {
        logic [CNT_W-1:0] stamp;
        logic [N-1:0]     fword;
    } rec_t;

    rec_t             mem [DEPTH];
    logic [CNT_W-1:0] pos;
    logic             hit;
    logic             full;
    logic             wr;

    assign hit  = en && (|word);
    assign full = (evt_cnt == EW'(DEPTH));
    assign wr   = hit && !full && !rst && !clr;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pos     <= '0;
            evt_cnt <= '0;
            ovf     <= 1'b0;
        end else if (en) begin
            pos <= pos + 1'b1;
            if (hit) begin
                if (full) ovf <= 1'b1;
                else      evt_cnt <= evt_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr) begin
            mem[evt_cnt[IW-1:0]] <= '{stamp: pos, fword: word};
        end
    end

    assign rd_stamp = mem[rd_idx].stamp;
    assign rd_word  = mem[rd_idx].fword;
endmodule

// File: rtl/nbr_loc_top.sv
module nbr_loc_top
    import nbr_loc_pkg::*;
#(
    parameter int N_INST    = 8,
    parameter int CNT_W     = 16,
    parameter int MEM_DEPTH = 16,
    localparam int IW       = $clog2(MEM_DEPTH),
    localparam int EW       = $clog2(MEM_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              scan_en,
    input  logic [N_INST-1:0] scan_out,
    input  logic [IW-1:0]     rd_idx,
    output logic [N_INST-1:0] fault_word,
    output logic [SIG_W-1:0]  sig,
    output logic [EW-1:0]     evt_cnt,
    output logic              ovf,
    output logic [CNT_W-1:0]  rd_stamp,
    output logic [N_INST-1:0] rd_word
);
    nbr_loc_ring #(.N(N_INST)) u_ring (
        .bits (scan_out),
        .word (fault_word)
    );

    nbr_loc_misr #(.N(N_INST)) u_misr (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr),
        .en   (scan_en),
        .word (fault_word),
        .sig  (sig)
    );

    nbr_loc_log #(.N(N_INST), .CNT_W(CNT_W), .DEPTH(MEM_DEPTH)) u_log (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .en       (scan_en),
        .word     (fault_word),
        .rd_idx   (rd_idx),
        .evt_cnt  (evt_cnt),
        .ovf      (ovf),
        .rd_stamp (rd_stamp),
        .rd_word  (rd_word)
    );
endmodule

// File: rtl/nbr_loc_chk.sv
module nbr_loc_chk #(
    parameter int N     = 8,
    parameter int DEPTH = 16,
    parameter int EW    = 5,
    parameter int SW    = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          clr,
    input logic          scan_en,
    input logic [N-1:0]  scan_out,
    input logic [N-1:0]  fault_word,
    input logic [EW-1:0] evt_cnt,
    input logic          ovf,
    input logic [SW-1:0] sig
);
    // R1: identical copies never raise a fault bit
    a_r1_agree_zero: assert property (@(posedge clk) disable iff (rst)
        ((scan_out == '0) || (scan_out == '1)) |-> (fault_word == '0));

    // R2: a single deviating copy flags exactly one bit
    a_r2_single_one: assert property (@(posedge clk) disable iff (rst)
        (($countones(scan_out) == 1) || ($countones(~scan_out) == 1))
            |-> ($countones(fault_word) == 1));

    // R5: each logged event advances the count by one
    a_r5_count_step: assert property (@(posedge clk) disable iff (rst)
        (scan_en && !clr && (|fault_word) && (evt_cnt != EW'(DEPTH)))
            |=> (evt_cnt == $past(evt_cnt) + 1'b1));

    // R6: idle cycles leave the state untouched
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!scan_en && !clr) |=> ($stable(evt_cnt) && $stable(sig) && $stable(ovf)));

    // R7: the count is bounded by the depth, and overflow is sticky
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        evt_cnt <= EW'(DEPTH));
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf && !clr) |=> ovf);

    // R9: clear zeroes the session state
    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> ((evt_cnt == '0) && !ovf && (sig == '0)));
endmodule

bind nbr_loc_top nbr_loc_chk #(
    .N(N_INST), .DEPTH(MEM_DEPTH), .EW(EW), .SW(nbr_loc_pkg::SIG_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr),
    .scan_en    (scan_en),
    .scan_out   (scan_out),
    .fault_word (fault_word),
    .evt_cnt    (evt_cnt),
    .ovf        (ovf),
    .sig        (sig)
);

// File: tb/nbr_loc_top_bench.sv
`timescale 1ns/1ps
module nbr_loc_top_bench;
    localparam int N     = 8;
    localparam int CW    = 16;
    localparam int DEPTH = 16;
    localparam int IW    = $clog2(DEPTH);
    localparam int EW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clr = 1'b0;
    logic          scan_en = 1'b0;
    logic [N-1:0]  scan_out = '0;
    logic [IW-1:0] rd_idx = '0;
    logic [N-1:0]  fault_word;
    logic [15:0]   sig;
    logic [EW-1:0] evt_cnt;
    logic          ovf;
    logic [CW-1:0] rd_stamp;
    logic [N-1:0]  rd_word;

    int n_chk = 0;
    int n_bad = 0;

    // model state
    int          m_cnt;
    int          m_evt;
    bit          m_ovf;
    logic [15:0] m_sig;
    logic [CW-1:0] m_stamp [DEPTH];
    logic [N-1:0]  m_word  [DEPTH];

    always #2 clk = ~clk;

    nbr_loc_top #(.N_INST(N), .CNT_W(CW), .MEM_DEPTH(DEPTH)) u_nbr_loc_top (
        .clk(clk), .rst(rst), .clr(clr), .scan_en(scan_en), .scan_out(scan_out),
        .rd_idx(rd_idx), .fault_word(fault_word), .sig(sig), .evt_cnt(evt_cnt),
        .ovf(ovf), .rd_stamp(rd_stamp), .rd_word(rd_word)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [N-1:0] exp_word(input logic [N-1:0] b);
        logic [N-1:0] w;
        for (int i = 0; i < N; i++) begin
            w[i] = (b[i] ^ b[(i + N - 1) % N]) & (b[i] ^ b[(i + 1) % N]);
        end
        return w;
    endfunction

    function automatic logic [15:0] exp_sig(input logic [15:0] s, input logic [N-1:0] w);
        logic [15:0] d;
        d = '0;
        for (int i = 0; i < N; i++) d[i % 16] = d[i % 16] ^ w[i];
        return {s[14:0], 1'b0} ^ (s[15] ? 16'h002D : 16'h0000) ^ d;
    endfunction

    task automatic model_clear();
        m_cnt = 0; m_evt = 0; m_ovf = 0; m_sig = '0;
    endtask

    // one shift cycle; checks word (R1), then registered state (R5, R7, R8)
    task automatic step(input bit en, input logic [N-1:0] b);
        logic [N-1:0] w;
        @(negedge clk);
        scan_en = en; scan_out = b;
        #1;
        w = exp_word(b);
        check("R1 fault word", 64'(fault_word), 64'(w));
        if (en) begin
            if (|w) begin
                if (m_evt < DEPTH) begin
                    m_stamp[m_evt] = CW'(m_cnt);
                    m_word[m_evt]  = w;
                    m_evt++;
                end else begin
                    m_ovf = 1;
                end
            end
            m_cnt++;
            m_sig = exp_sig(m_sig, w);
        end
        @(posedge clk); #1;
        check("R5 evt_cnt", 64'(evt_cnt), 64'(m_evt));
        check("R7 ovf", 64'(ovf), 64'(m_ovf));
        check("R8 sig", 64'(sig), 64'(m_sig));
    endtask

    task automatic check_log(input string req);
        for (int k = 0; k < m_evt; k++) begin
            rd_idx = IW'(k);
            #1;
            check({req, " R10 stamp"}, 64'(rd_stamp), 64'(m_stamp[k]));
            check({req, " R10 word"}, 64'(rd_word), 64'(m_word[k]));
        end
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1; scan_en = 1'b1; scan_out = 8'h01;  // clear outranks a live fault
        @(posedge clk); #1;
        clr = 1'b0; scan_en = 1'b0;
        model_clear();
        check("R9 evt_cnt", 64'(evt_cnt), 64'd0);
        check("R9 ovf", 64'(ovf), 64'd0);
        check("R9 sig", 64'(sig), 64'd0);
    endtask

    task automatic t_reset();
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        model_clear();
        check("R9 reset evt_cnt", 64'(evt_cnt), 64'd0);
        check("R9 reset ovf", 64'(ovf), 64'd0);
        check("R9 reset sig", 64'(sig), 64'd0);
    endtask

    task automatic t_single();
        do_clear();
        step(1, 8'h00);
        step(1, 8'hFF);
        for (int i = 0; i < N; i++) begin
            step(1, N'(1) << i);
            check("R2 one bit", 64'(fault_word), 64'(N'(1) << i));
            step(1, ~(N'(1) << i));
            check("R2 one bit inverted", 64'(fault_word), 64'(N'(1) << i));
        end
        check_log("R5 single");
        check("R4 stamps reflect position", 64'(m_stamp[0]), 64'd2);
    endtask

    task automatic t_multi();
        do_clear();
        step(1, 8'b0000_1010);
        check("R3 gap pair", 64'(fault_word), 64'(8'b0000_1110));
        step(1, 8'b0000_0110);
        check("R3 adjacent pair masked", 64'(fault_word), 64'd0);
        step(1, 8'b1000_0001);
        check("R3 wrap adjacent masked", 64'(fault_word), 64'd0);
        step(1, 8'b0101_0100);
        check("R3 triple", 64'(fault_word), 64'(exp_word(8'b0101_0100)));
        step(1, 8'b0100_0001);
        check("R3 wrap pair", 64'(fault_word), 64'(8'b1100_0001));
        check_log("R3 records");
    endtask

    task automatic t_idle();
        logic [15:0] s0;
        do_clear();
        step(1, 8'h04);
        s0 = sig;
        step(0, 8'h10);
        step(0, 8'h20);
        check("R6 no log when idle", 64'(evt_cnt), 64'd1);
        check("R6 sig hold", 64'(sig), 64'(s0));
        step(1, 8'h80);
        check_log("R4 R6 stamp after idle");
        check("R4 counter held during idle", 64'(m_stamp[1]), 64'd1);
    endtask

    task automatic t_overflow();
        do_clear();
        for (int k = 0; k < DEPTH + 3; k++) begin
            step(1, N'(1) << (k % N));
            step(1, 8'h00);
        end
        check("R7 cnt at depth", 64'(evt_cnt), 64'(DEPTH));
        check("R7 ovf set", 64'(ovf), 64'd1);
        step(1, 8'h00);
        check("R7 ovf sticky", 64'(ovf), 64'd1);
        check_log("R7 records kept");
        do_clear();
    endtask

    task automatic t_sig();
        do_clear();
        for (int k = 0; k < 40; k++) begin
            step(1, 8'(k * 37 + 5));
        end
        check("R8 signature after stream", 64'(sig), 64'(m_sig));
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_single();
        t_multi();
        t_idle();
        t_overflow();
        t_sig();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule